// File: doc/BRIEF.md
# Write Enable and Status Protection Unit

This block decides whether a serial memory device may accept a write. It keeps the write-enable latch and a small status register whose only writable field is a protect-enable bit. Together with the active-low write-protect pin, these give two permit outputs. One permit covers array writes. The other covers status-register writes. A serial front end feeds the block with single-cycle command strobes (write-enable set, write-enable clear, status write) and with the incoming status byte. It also passes through the chip-select level. The write engine reports whether its internal write cycle is running.

A status write goes through three steps. It is armed by the command strobe and staged when its data byte arrives. It is committed when chip select rises. While the transfer is still open, a falling protect pin can cancel it. A falling pin has no effect after the commit, once the internal write is underway. When the protect-enable bit is clear, the pin is ignored.

Top module: `wprot_unit`

## Requirements
- R1: After reset, `status_o` reads 0x00 (with the busy input low), and both `mem_wr_ok_o` and `sr_wr_ok_o` are 0.
- R2: A pulse on `cmd_wren_i` (command 0x06) sets the write-enable latch, seen as `status_o[1]`=1 one cycle later. A pulse on `cmd_wrdi_i` (command 0x04) clears it.
- R3: `mem_wr_ok_o` is 1 only while the latch is set. A status write issued while the latch is clear never commits.
- R4: Status layout: bit 0 follows `wcyc_busy_i`, bit 1 is the latch, and bit 7 is protect-enable. Bits 2 to 6 read 0. Bits 0 to 6 of a written byte have no effect.
- R5: A status write with the latch set and the pin high loads byte bit 7 into protect-enable on the cycle after chip select rises. `sr_commit_o` pulses high for exactly that one cycle.
- R6: With protect-enable 1 and `wp_n_i` low, `sr_wr_ok_o` is 0. A status write does not commit and leaves protect-enable unchanged.
- R7: With protect-enable 0, `wp_n_i` has no effect: a status write commits with the pin low.
- R8: A falling edge on `wp_n_i` while chip select is low and a status write is pending cancels that write when protect-enable is 1. This holds even if the pin returns high before chip select rises.
- R9: Once a status write has committed, a later fall of `wp_n_i` leaves the written protect-enable value in place.
- R10: A falling edge on `wcyc_busy_i` (write cycle completed) clears the latch. This clear takes priority over a set strobe in the same cycle.
- R11: A rise of chip select without a completed status byte does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip-select level, low while a transfer is open |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_wren_i | input | 1 | Write-enable command strobe |
| cmd_wrdi_i | input | 1 | Write-disable command strobe |
| cmd_sr_wr_i | input | 1 | Status-write command strobe |
| sr_byte_vld_i | input | 1 | Status data byte valid strobe |
| sr_byte_i | input | 8 | Status data byte |
| wcyc_busy_i | input | 1 | Internal write cycle running |
| status_o | output | 8 | Status byte for reads |
| mem_wr_ok_o | output | 1 | Array write permitted |
| sr_wr_ok_o | output | 1 | Status write permitted now |
| sr_commit_o | output | 1 | One-cycle pulse when a status write is applied |

## Verification
A latch that is stuck or lost shows at `status_o[1]` and `mem_wr_ok_o` on the cycle after the strobe or completion edge. A wrong protect-enable value shows at `status_o[7]` and `sr_wr_ok_o` in the same way. A pending-write phase held in the wrong state is hidden until chip select rises. It then appears one cycle later as a missing or extra `sr_commit_o` pulse and a wrong bit 7. For this reason every status-write scenario checks the commit pulse and the status byte right after the rise.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int SR_W     = 8;
    localparam int BIT_WIP  = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_WPEN = 7;

    localparam logic [SR_W-1:0] WR_MASK  = SR_W'(1) << BIT_WPEN;
    localparam logic [SR_W-1:0] SR_RESET = '0;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_ARMED  = 2'd1,
        SW_STAGED = 2'd2
    } sw_phase_t;

    typedef struct packed {
        logic cs_rise;
        logic cs_fall;
        logic wp_fall;
        logic busy_fall;
    } edges_t;

    function automatic logic pin_blocks(input logic wpen, input logic wp_n);
        return wpen & ~wp_n;
    endfunction

    function automatic logic [SR_W-1:0] merge_status(
        input logic [SR_W-1:0] wr_bits,
        input logic            wel,
        input logic            wip
    );
        logic [SR_W-1:0] s;
        s = wr_bits & WR_MASK;
        s[BIT_WEL] = wel;
        s[BIT_WIP] = wip;
        return s;
    endfunction

endpackage

// File: rtl/wprot_edges.sv
module wprot_edges #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= RST_VAL[i];
            else     prev_q[i] <= sig_i[i];
        end
        assign rise_o[i] = ~prev_q[i] &  sig_i[i];
        assign fall_o[i] =  prev_q[i] & ~sig_i[i];
    end

endmodule

// File: rtl/wprot_wel.sv
module wprot_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic done_i,
    output logic wel_o
);

    always_ff @(posedge clk) begin
        if (rst)         wel_o <= 1'b0;
        else if (done_i) wel_o <= 1'b0;
        else if (clr_i)  wel_o <= 1'b0;
        else if (set_i)  wel_o <= 1'b1;
    end

endmodule

// File: rtl/wprot_srctl.sv
module wprot_srctl
    import wprot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n_i,
    input  logic            wp_n_i,
    input  logic            wel_i,
    input  logic            wpen_i,
    input  edges_t          edg_i,
    input  logic            cmd_i,
    input  logic            vld_i,
    input  logic [SR_W-1:0] byte_i,
    output logic            commit_o,
    output logic [SR_W-1:0] staged_o
);

    sw_phase_t       phase_q;
    logic [SR_W-1:0] staged_q;
    logic            cancel;

    assign cancel = (phase_q != SW_IDLE) && edg_i.wp_fall && wpen_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= SW_IDLE;
            staged_q <= SR_RESET;
        end else if (edg_i.cs_rise || edg_i.cs_fall || cancel) begin
            phase_q  <= SW_IDLE;
        end else begin
            unique case (phase_q)
                SW_IDLE:   if (cmd_i && wel_i && !cs_n_i) phase_q <= SW_ARMED;
                SW_ARMED:  if (vld_i) begin
                               phase_q  <= SW_STAGED;
                               staged_q <= byte_i & WR_MASK;
                           end
                SW_STAGED: phase_q <= SW_STAGED;
                default:   phase_q <= SW_IDLE;
            endcase
        end
    end

    assign commit_o = edg_i.cs_rise && (phase_q == SW_STAGED) && wel_i
                      && !pin_blocks(wpen_i, wp_n_i);
    assign staged_o = staged_q;

endmodule

// File: rtl/wprot_store.sv
module wprot_store
    import wprot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            commit_i,
    input  logic [SR_W-1:0] data_i,
    output logic [SR_W-1:0] bits_o,
    output logic            pulse_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_o  <= SR_RESET;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= commit_i;
            if (commit_i) bits_o <= (bits_o & ~WR_MASK) | (data_i & WR_MASK);
        end
    end

endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n_i,
    input  logic            wp_n_i,
    input  logic            cmd_wren_i,
    input  logic            cmd_wrdi_i,
    input  logic            cmd_sr_wr_i,
    input  logic            sr_byte_vld_i,
    input  logic [SR_W-1:0] sr_byte_i,
    input  logic            wcyc_busy_i,
    output logic [SR_W-1:0] status_o,
    output logic            mem_wr_ok_o,
    output logic            sr_wr_ok_o,
    output logic            sr_commit_o
);

    localparam int NE = 3;
    localparam logic [NE-1:0] EDGE_RST = 3'b011;

    logic [NE-1:0]   rise, fall;
    edges_t          edg;
    logic            wel, commit;
    logic [SR_W-1:0] staged, wr_bits;

    wprot_edges #(.W(NE), .RST_VAL(EDGE_RST)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .sig_i  ({wcyc_busy_i, wp_n_i, cs_n_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        edg.cs_rise   = rise[0];
        edg.cs_fall   = fall[0];
        edg.wp_fall   = fall[1];
        edg.busy_fall = fall[2];
    end

    wprot_wel u_wel (
        .clk    (clk),
        .rst    (rst),
        .set_i  (cmd_wren_i),
        .clr_i  (cmd_wrdi_i),
        .done_i (edg.busy_fall),
        .wel_o  (wel)
    );

    wprot_srctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cs_n_i   (cs_n_i),
        .wp_n_i   (wp_n_i),
        .wel_i    (wel),
        .wpen_i   (wr_bits[BIT_WPEN]),
        .edg_i    (edg),
        .cmd_i    (cmd_sr_wr_i),
        .vld_i    (sr_byte_vld_i),
        .byte_i   (sr_byte_i),
        .commit_o (commit),
        .staged_o (staged)
    );

    wprot_store u_store (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .data_i   (staged),
        .bits_o   (wr_bits),
        .pulse_o  (sr_commit_o)
    );

    assign status_o    = merge_status(wr_bits, wel, wcyc_busy_i);
    assign mem_wr_ok_o = wel;
    assign sr_wr_ok_o  = wel & ~pin_blocks(wr_bits[BIT_WPEN], wp_n_i);

endmodule

// File: rtl/wprot_chk.sv
module wprot_chk (
    input logic clk,
    input logic rst,
    input logic cs_n_i,
    input logic wp_n_i,
    input logic wcyc_busy_i,
    input logic wel_i,
    input logic wpen_i,
    input logic sr_commit_o
);

    assert_commit_single_R5: assert property (@(posedge clk) disable iff (rst)
        sr_commit_o |=> !sr_commit_o);

    assert_wpen_only_on_commit_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(wpen_i) |-> sr_commit_o);

    assert_commit_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
        sr_commit_o |-> $past(wel_i));

    assert_commit_not_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        sr_commit_o |-> !($past(wpen_i) && !$past(wp_n_i)));

    assert_commit_on_cs_rise_R11: assert property (@(posedge clk) disable iff (rst)
        sr_commit_o |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

    assert_done_clears_wel_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(wcyc_busy_i) |=> !wel_i);

endmodule

bind wprot_unit wprot_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_i      (cs_n_i),
    .wp_n_i      (wp_n_i),
    .wcyc_busy_i (wcyc_busy_i),
    .wel_i       (status_o[wprot_pkg::BIT_WEL]),
    .wpen_i      (status_o[wprot_pkg::BIT_WPEN]),
    .sr_commit_o (sr_commit_o)
);

// File: tb/tb_wprot_unit.sv
module tb_wprot_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n_i, wp_n_i, cmd_wren_i, cmd_wrdi_i, cmd_sr_wr_i;
    logic       sr_byte_vld_i, wcyc_busy_i;
    logic [7:0] sr_byte_i, status_o;
    logic       mem_wr_ok_o, sr_wr_ok_o, sr_commit_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    wprot_unit dut (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wren();
        cmd_wren_i = 1'b1; tick(); cmd_wren_i = 1'b0;
    endtask

    task automatic busy_cycle();
        wcyc_busy_i = 1'b1; tick();
        chk("R4 busy bit", {7'd0, status_o[0]}, 8'h01);
        wcyc_busy_i = 1'b0; tick();
        chk("R10 latch cleared after write cycle", {7'd0, status_o[1]}, 8'h00);
    endtask

    task automatic sr_write(input logic [7:0] b, input bit send, input bit glitch,
                            input bit exp_commit, input string req);
        cs_n_i = 1'b0; tick();
        cmd_sr_wr_i = 1'b1; tick(); cmd_sr_wr_i = 1'b0;
        if (send) begin
            sr_byte_vld_i = 1'b1; sr_byte_i = b; tick(); sr_byte_vld_i = 1'b0;
        end
        if (glitch) begin
            wp_n_i = 1'b0; tick(); wp_n_i = 1'b1; tick();
        end
        tick();
        cs_n_i = 1'b1; tick();
        chk({req, " commit pulse"}, {7'd0, sr_commit_o}, {7'd0, exp_commit});
        tick();
        chk("R5 pulse single", {7'd0, sr_commit_o}, 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h00);
        chk("R1 mem permit", {7'd0, mem_wr_ok_o}, 8'h00);
        chk("R1 sr permit", {7'd0, sr_wr_ok_o}, 8'h00);
    endtask

    task automatic t_latch();
        wren(); tick();
        chk("R2 set", status_o, 8'h02);
        chk("R3 mem permit set", {7'd0, mem_wr_ok_o}, 8'h01);
        cmd_wrdi_i = 1'b1; tick(); cmd_wrdi_i = 1'b0; tick();
        chk("R2 clear", status_o, 8'h00);
        chk("R3 mem permit clear", {7'd0, mem_wr_ok_o}, 8'h00);
    endtask

    task automatic t_no_wel();
        sr_write(8'h80, 1'b1, 1'b0, 1'b0, "R3 no latch");
        chk("R3 wpen unchanged", status_o, 8'h00);
    endtask

    task automatic t_write_set();
        wren();
        sr_write(8'h83, 1'b1, 1'b0, 1'b1, "R5 write");
        chk("R4 R5 status after write", status_o, 8'h82);
        wp_n_i = 1'b0; tick();
        chk("R9 wpen kept after pin fall", {7'd0, status_o[7]}, 8'h01);
        busy_cycle();
        wp_n_i = 1'b1; tick();
        chk("R4 status idle", status_o, 8'h80);
    endtask

    task automatic t_blocked();
        wren(); wp_n_i = 1'b0; tick();
        chk("R6 sr permit", {7'd0, sr_wr_ok_o}, 8'h00);
        sr_write(8'h00, 1'b1, 1'b0, 1'b0, "R6 blocked");
        chk("R6 wpen unchanged", {7'd0, status_o[7]}, 8'h01);
        wp_n_i = 1'b1; tick();
        chk("R6 sr permit pin high", {7'd0, sr_wr_ok_o}, 8'h01);
    endtask

    task automatic t_cancel();
        sr_write(8'h00, 1'b1, 1'b1, 1'b0, "R8 cancel");
        chk("R8 wpen unchanged", {7'd0, status_o[7]}, 8'h01);
    endtask

    task automatic t_no_data();
        sr_write(8'h00, 1'b0, 1'b0, 1'b0, "R11 no byte");
        chk("R11 wpen unchanged", {7'd0, status_o[7]}, 8'h01);
    endtask

    task automatic t_clear_then_ignore();
        sr_write(8'h00, 1'b1, 1'b0, 1'b1, "R5 clear wpen");
        chk("R5 wpen cleared", {7'd0, status_o[7]}, 8'h00);
        busy_cycle();
        wren(); wp_n_i = 1'b0; tick();
        chk("R7 sr permit pin low", {7'd0, sr_wr_ok_o}, 8'h01);
        sr_write(8'h80, 1'b1, 1'b0, 1'b1, "R7 pin ignored");
        chk("R7 wpen set", {7'd0, status_o[7]}, 8'h01);
        wp_n_i = 1'b1;
        busy_cycle();
    endtask

    task automatic t_done_priority();
        wcyc_busy_i = 1'b1; tick();
        wcyc_busy_i = 1'b0; cmd_wren_i = 1'b1; tick(); cmd_wren_i = 1'b0; tick();
        chk("R10 clear beats set", {7'd0, status_o[1]}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; cs_n_i = 1'b1; wp_n_i = 1'b1; cmd_wren_i = 1'b0;
        cmd_wrdi_i = 1'b0; cmd_sr_wr_i = 1'b0; sr_byte_vld_i = 1'b0;
        sr_byte_i = 8'h00; wcyc_busy_i = 1'b0;
        repeat (3) tick();
        rst = 1'b0; tick();
        t_reset();
        t_latch();
        t_no_wel();
        t_write_set();
        t_blocked();
        t_cancel();
        t_no_data();
        t_clear_then_ignore();
        t_done_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule